// File: doc/BRIEF.md
# Eight-Pin GPIO Register Block

This block is the register side of an eight-pin general-purpose I/O port. A bus master reaches it through a 32-bit, word-addressed request/response interface on a 12-bit byte offset. It holds the pin data and the pin direction. It also holds the interrupt configuration words: level/edge sense, both-edge enable, event polarity and interrupt enable. A mode-select word is stored here as well. Pins set as outputs are driven from the stored data. Pins set as inputs are sampled through a two-flop synchronizer into the same data register.

The lower quarter of the offset space is a data window. Offset bits [9:2] act as a per-pin mask, so software can read or change any subset of pins without a read-modify-write. The edge and level detector is a separate block. It reads its configuration from the `cfg_*` ports and returns its raw status on `irq_raw`. A write to the clear register sends a one-cycle `irq_clear` pulse back to that detector. The top of the offset space holds eight read-only identification words.

The bus side is a two-state machine. In **ST_IDLE** it asserts `req_ready`. The transition **accept** (`req_valid` high while idle) performs the write or captures the read data and moves to **ST_RESP**. ST_RESP asserts `rsp_valid` for exactly one cycle. The transition **complete** then returns unconditionally to ST_IDLE.

Top module: `gpio_regfile`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` is 0, `pin_out` is 0, all `cfg_*` outputs are 0 and `req_ready` is 1.
- R2: A request accepted in ST_IDLE (req_valid and req_ready high at a clock edge) is answered by `rsp_valid` high for exactly the next cycle. `req_ready` is low during that cycle.
- R3: A read at a byte offset below 0x400 returns the 8-bit data register ANDed with offset bits [9:2], zero-extended to 32 bits.
- R4: A write at a byte offset below 0x400 changes data bit i only when offset bit (i+2) is 1 and direction bit i is 1. All other data bits keep their value.
- R5: Direction (0x400), sense (0x404), both-edge (0x408), event (0x40C), enable (0x410) and mode select (0x420) each store only write bits [7:0]. Bits [31:8] read back as zero.
- R6: A read of 0x414 returns `irq_raw`. A read of 0x418 returns `irq_raw` ANDed with the enable register.
- R7: A write to 0x41C drives `irq_clear` with write bits [7:0] for the single ST_RESP cycle that follows, and `irq_clear` is zero at all other times. A read of 0x41C returns zero.
- R8: Reads of word offsets 0xFE0 to 0xFFC return, in ascending order, 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with bits [31:8] zero.
- R9: Writes to 0x414, 0x418, 0x424–0xFDC and 0xFE0–0xFFC change no state. Reads of unmapped offsets return zero.
- R10: A change on an input pin reaches the data register at the third rising clock edge after it appears on `pin_in`, through two synchronizer flops. Changes on pins set as outputs never reach the data register.
- R11: `pin_oe` equals the direction register and `pin_out` equals the data register.
- R12: `cfg_sense`, `cfg_both`, `cfg_event`, `cfg_enable` and `cfg_mode` always equal the sense, both-edge, event, enable and mode-select registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (ST_IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle (ST_RESP) |
| rsp_rdata | output | 32 | Read data, valid while rsp_valid |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| cfg_sense | output | 8 | Sense configuration to detector |
| cfg_both | output | 8 | Both-edge configuration to detector |
| cfg_event | output | 8 | Event polarity configuration to detector |
| cfg_enable | output | 8 | Interrupt enable to detector |
| cfg_mode | output | 8 | Stored mode-select bits |
| irq_raw | input | 8 | Raw interrupt status from detector |
| irq_clear | output | 8 | One-cycle clear pulse to detector |

## Verification
The hardest case to reach from the ports is a data register that holds output bits and input bits at once. A masked write must update only the output bits, while the input bits are being refreshed from the synchronizer. The stimulus first sets a split direction pattern and writes through windows whose masks cover input pins. It then drives `pin_in` one cycle before a read is accepted. The data must show the old input value at that read and the new one a few cycles later, with the output bits untouched throughout.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    typedef enum logic [3:0] {
        SEL_DATA,
        SEL_DIR,
        SEL_SENSE,
        SEL_BOTH,
        SEL_EVENT,
        SEL_ENABLE,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR,
        SEL_MODE,
        SEL_ID,
        SEL_NONE
    } reg_sel_e;

    // Identification bytes, one per word, ascending offset.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h61;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h14;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        if (addr[ADDR_W-1 -: 2] == 2'b00) begin
            sel = SEL_DATA;
        end else if (addr[ADDR_W-1:5] == '1) begin
            sel = SEL_ID;
        end else begin
            case (word)
                WORD_W'(10'h100): sel = SEL_DIR;
                WORD_W'(10'h101): sel = SEL_SENSE;
                WORD_W'(10'h102): sel = SEL_BOTH;
                WORD_W'(10'h103): sel = SEL_EVENT;
                WORD_W'(10'h104): sel = SEL_ENABLE;
                WORD_W'(10'h105): sel = SEL_RAW;
                WORD_W'(10'h106): sel = SEL_MASKED;
                WORD_W'(10'h107): sel = SEL_CLEAR;
                WORD_W'(10'h108): sel = SEL_MODE;
                default:          sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int SYNC_STG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] cfg_sense,
    output logic [NUM_PINS-1:0] cfg_both,
    output logic [NUM_PINS-1:0] cfg_event,
    output logic [NUM_PINS-1:0] cfg_enable,
    output logic [NUM_PINS-1:0] cfg_mode,
    input  logic [NUM_PINS-1:0] irq_raw,
    output logic [NUM_PINS-1:0] irq_clear
);
    localparam int MASK_LSB = 2;

    bus_state_e state_q, state_d;
    reg_sel_e   sel;

    logic [NUM_PINS-1:0] data_q, dir_q, sense_q, both_q, event_q, enable_q, mode_q;
    logic [NUM_PINS-1:0] clear_q, pin_sync, win_mask;
    logic [DATA_W-1:0]   rdata_q, rd_mux;
    logic                accept, wr_acc;

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign wr_acc   = accept && req_write;
    assign win_mask = req_addr[MASK_LSB +: NUM_PINS];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;   // accept
            ST_RESP: state_d = ST_IDLE;               // complete
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
        endcase
    end

    // Data register: output bits from masked writes, input bits from pins
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_data
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[i] <= 1'b0;
            end else if (dir_q[i]) begin
                if (wr_acc && sel == SEL_DATA && win_mask[i])
                    data_q[i] <= req_wdata[i];
            end else begin
                data_q[i] <= pin_sync[i];
            end
        end
    end

    // Configuration registers and clear pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '0;
            sense_q  <= '0;
            both_q   <= '0;
            event_q  <= '0;
            enable_q <= '0;
            mode_q   <= '0;
            clear_q  <= '0;
        end else begin
            clear_q <= '0;
            if (wr_acc) begin
                case (sel)
                    SEL_DIR:    dir_q    <= req_wdata[NUM_PINS-1:0];
                    SEL_SENSE:  sense_q  <= req_wdata[NUM_PINS-1:0];
                    SEL_BOTH:   both_q   <= req_wdata[NUM_PINS-1:0];
                    SEL_EVENT:  event_q  <= req_wdata[NUM_PINS-1:0];
                    SEL_ENABLE: enable_q <= req_wdata[NUM_PINS-1:0];
                    SEL_MODE:   mode_q   <= req_wdata[NUM_PINS-1:0];
                    SEL_CLEAR:  clear_q  <= req_wdata[NUM_PINS-1:0];
                    default:    ;
                endcase
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_DATA:   rd_mux[NUM_PINS-1:0] = data_q & win_mask;
            SEL_DIR:    rd_mux[NUM_PINS-1:0] = dir_q;
            SEL_SENSE:  rd_mux[NUM_PINS-1:0] = sense_q;
            SEL_BOTH:   rd_mux[NUM_PINS-1:0] = both_q;
            SEL_EVENT:  rd_mux[NUM_PINS-1:0] = event_q;
            SEL_ENABLE: rd_mux[NUM_PINS-1:0] = enable_q;
            SEL_RAW:    rd_mux[NUM_PINS-1:0] = irq_raw;
            SEL_MASKED: rd_mux[NUM_PINS-1:0] = irq_raw & enable_q;
            SEL_MODE:   rd_mux[NUM_PINS-1:0] = mode_q;
            SEL_ID:     rd_mux[7:0]          = id_byte(req_addr[4:2]);
            SEL_CLEAR, SEL_NONE: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (accept) rdata_q <= req_write ? '0 : rd_mux;
    end

    assign rsp_rdata  = rdata_q;
    assign pin_out    = data_q;
    assign pin_oe     = dir_q;
    assign cfg_sense  = sense_q;
    assign cfg_both   = both_q;
    assign cfg_event  = event_q;
    assign cfg_enable = enable_q;
    assign cfg_mode   = mode_q;
    assign irq_clear  = clear_q;
endmodule

// File: rtl/gpio_regfile_chk.sv
module gpio_regfile_chk #(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   req_wdata,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] cfg_enable,
    input logic [NUM_PINS-1:0] irq_raw,
    input logic [NUM_PINS-1:0] irq_clear
);
    logic acc;
    assign acc = req_valid && req_ready;

    // R2
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    // R2
    single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    busy_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R11
    oe_tracks_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && req_addr == 12'h400) |=> pin_oe == $past(req_wdata[NUM_PINS-1:0]));

    // R6
    masked_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_addr == 12'h418)
        |=> rsp_rdata == DATA_W'($past(irq_raw & cfg_enable)));

    // R7
    clear_only_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear != '0) |-> rsp_valid);

    // R8
    id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_addr[ADDR_W-1:5] == '1) |=> rsp_rdata[DATA_W-1:8] == '0);
endmodule

bind gpio_regfile gpio_regfile_chk #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .pin_oe     (pin_oe),
    .cfg_enable (cfg_enable),
    .irq_raw    (irq_raw),
    .irq_clear  (irq_clear)
);

// File: tb/test_gpio_regfile.sv
`timescale 1ns/1ps
module test_gpio_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic [7:0]  cfg_sense, cfg_both, cfg_event, cfg_enable, cfg_mode;
    logic [7:0]  irq_raw = '0;
    logic [7:0]  irq_clear;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    gpio_regfile i_gpio_regfile (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .cfg_sense(cfg_sense), .cfg_both(cfg_both), .cfg_event(cfg_event),
        .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .irq_raw(irq_raw), .irq_clear(irq_clear)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 12'h400, 32'hFFFF_FF0F, 32'h0, 8'd5},
        '{1'b0, 12'h400, 32'h0, 32'h0000_000F, 8'd5},   // R5 direction
        '{1'b1, 12'h3FC, 32'h0000_00A5, 32'h0, 8'd4},
        '{1'b0, 12'h3FC, 32'h0, 32'h0000_0005, 8'd4},   // R4 inputs untouched
        '{1'b1, 12'h004, 32'h0, 32'h0, 8'd4},
        '{1'b0, 12'h3FC, 32'h0, 32'h0000_0004, 8'd4},   // R4 only bit0 cleared
        '{1'b0, 12'h010, 32'h0, 32'h0000_0004, 8'd3},   // R3 mask bit2
        '{1'b0, 12'h008, 32'h0, 32'h0000_0000, 8'd3},   // R3 mask bit1
        '{1'b1, 12'h0C0, 32'hFFFF_FFFF, 32'h0, 8'd4},
        '{1'b0, 12'h3FC, 32'h0, 32'h0000_0004, 8'd4},   // R4 input pins ignore write
        '{1'b1, 12'h404, 32'h0000_1234, 32'h0, 8'd5},
        '{1'b0, 12'h404, 32'h0, 32'h0000_0034, 8'd5},
        '{1'b1, 12'h408, 32'h0000_00AB, 32'h0, 8'd5},
        '{1'b0, 12'h408, 32'h0, 32'h0000_00AB, 8'd5},
        '{1'b1, 12'h40C, 32'hFF00_005A, 32'h0, 8'd5},
        '{1'b0, 12'h40C, 32'h0, 32'h0000_005A, 8'd5},
        '{1'b1, 12'h410, 32'h0000_00F0, 32'h0, 8'd5},
        '{1'b0, 12'h410, 32'h0, 32'h0000_00F0, 8'd5},
        '{1'b1, 12'h420, 32'hFFFF_FF3C, 32'h0, 8'd5},
        '{1'b0, 12'h420, 32'h0, 32'h0000_003C, 8'd5},
        '{1'b0, 12'h41C, 32'h0, 32'h0000_0000, 8'd7},   // R7 clear reads zero
        '{1'b0, 12'h500, 32'h0, 32'h0000_0000, 8'd9},   // R9 unmapped read
        '{1'b1, 12'hFE0, 32'h0000_0000, 32'h0, 8'd9},
        '{1'b0, 12'hFE0, 32'h0, 32'h0000_0061, 8'd9},   // R9 id not writable
        '{1'b1, 12'h500, 32'hFFFF_FFFF, 32'h0, 8'd9},
        '{1'b0, 12'h404, 32'h0, 32'h0000_0034, 8'd9}    // R9 no alias write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic rv, output logic [7:0] clr);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        rd  = rsp_rdata;
        rv  = rsp_valid;
        clr = irq_clear;
    endtask

    initial begin
        #2_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        rv;
        logic [7:0]  clr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
        check("R1 pin_out", {24'h0, pin_out}, 32'h0);
        check("R1 cfg", {cfg_sense, cfg_both, cfg_event, cfg_enable}, 32'h0);
        check("R1 req_ready", {31'h0, req_ready}, 32'h1);
        for (int a = 12'h400; a <= 12'h420; a += 4) begin
            access(1'b0, a[11:0], 32'h0, rd, rv, clr);
            check("R1 reg read", rd, 32'h0);
        end

        // R2 handshake timing
        access(1'b0, 12'h400, 32'h0, rd, rv, clr);
        check("R2 rsp_valid in response cycle", {31'h0, rv}, 32'h1);
        check("R2 req_ready low in response cycle", {31'h0, req_ready}, 32'h0);
        @(negedge clk);
        check("R2 rsp_valid dropped", {31'h0, rsp_valid}, 32'h0);
        check("R2 req_ready back", {31'h0, req_ready}, 32'h1);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            access(VECS[v].wr, VECS[v].addr, VECS[v].wdata, rd, rv, clr);
            if (!VECS[v].wr)
                check($sformatf("R%0d vector %0d", VECS[v].req, v), rd, VECS[v].exp);
        end

        // R11 and R12 pin and configuration outputs
        check("R11 pin_oe", {24'h0, pin_oe}, 32'h0000_000F);
        check("R11 pin_out", {24'h0, pin_out}, 32'h0000_0004);
        check("R12 cfg", {cfg_sense, cfg_both, cfg_event, cfg_enable}, 32'h34AB_5AF0);
        check("R12 cfg_mode", {24'h0, cfg_mode}, 32'h0000_003C);

        // R6 status reads
        irq_raw = 8'h3C;
        access(1'b0, 12'h414, 32'h0, rd, rv, clr);
        check("R6 raw status", rd, 32'h0000_003C);
        access(1'b0, 12'h418, 32'h0, rd, rv, clr);
        check("R6 masked status", rd, 32'h0000_0030);
        access(1'b1, 12'h418, 32'hFFFF_FFFF, rd, rv, clr);
        access(1'b0, 12'h410, 32'h0, rd, rv, clr);
        check("R9 status write ignored", rd, 32'h0000_00F0);

        // R7 clear pulse
        check("R7 idle clear", {24'h0, irq_clear}, 32'h0);
        access(1'b1, 12'h41C, 32'h0000_01A5, rd, rv, clr);
        check("R7 clear pulse", {24'h0, clr}, 32'h0000_00A5);
        @(negedge clk);
        check("R7 clear one cycle", {24'h0, irq_clear}, 32'h0);

        // R8 identification words
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            case (k)
                0: e = 8'h61; 1: e = 8'h10; 2: e = 8'h14; 3: e = 8'h00;
                4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
            endcase
            access(1'b0, 12'hFE0 + 12'(4 * k), 32'h0, rd, rv, clr);
            check($sformatf("R8 id word %0d", k), rd, {24'h0, e});
        end

        // R10 synchronizer latency; output pins ignore pin_in
        @(negedge clk);
        pin_in = 8'hFF;
        access(1'b0, 12'h3FC, 32'h0, rd, rv, clr);
        check("R10 not yet synchronized", rd, 32'h0000_0004);
        repeat (3) @(negedge clk);
        access(1'b0, 12'h3FC, 32'h0, rd, rv, clr);
        check("R10 synchronized inputs", rd, 32'h0000_00F4);
        access(1'b1, 12'h3FC, 32'h0000_0000, rd, rv, clr);
        access(1'b0, 12'h3FC, 32'h0, rd, rv, clr);
        check("R4 masked write with live inputs", rd, 32'h0000_00F0);
        check("R11 pin_out follows data", {24'h0, pin_out}, 32'h0000_00F0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule